// File: doc/BRIEF.md
# Software Command Channel Controller

This block is one software-facing command channel. It sits between a processor register bus and a downstream serial power-management bus engine. Software first loads a data word, which matters only for writes, and then issues a packed command word. The channel unpacks the word and offers it to the downstream engine over a request/acknowledge handshake. It then waits until the engine reports completion.

A write returns the channel to idle as soon as the engine finishes. A read captures the returned word and keeps it in a hold state until software writes an explicit valid-clear. A status register shows the state code and a sticky error flag. Software polls that register to learn when it may issue the next command and when read data is ready.

The state machine has four states:
- IDLE (code 0) is left through the transition *issue* on a command write and goes to WAIT_ACK.
- WAIT_ACK (code 1) asserts the request and takes the transition *accept* to XFER on `dn_ack`.
- XFER (code 2) takes the transition *finish_wr* to IDLE, or *finish_rd* to HOLD, on `dn_done`.
- HOLD (code 6) takes the transition *release* to IDLE on a valid-clear write with bit 0 set.

Top module: `cmd_chan_top`

## Requirements
- R1: After reset the state is IDLE, the status register reads 0, and `dn_req` is low.
- R2: The channel's registers respond only at base `CHAN_SEL*0x40`. The offsets are: command 0x00, write data 0x04, read data 0x14, valid clear 0x24, status 0x28. A write to another channel's window changes nothing, and a read from it returns 0.
- R3: A command write in IDLE moves the state to WAIT_ACK (code 1) one cycle later. The unpacked fields appear on the request outputs: class in bits [31:30], write flag in bit 29, target ID in bits [27:24], byte count minus one in bits [23:16], address in bits [15:0].
- R4: `dn_req` stays high in WAIT_ACK until `dn_ack` is seen. The state then becomes XFER (code 2) and `dn_req` drops.
- R5: For a write command, `dn_wdata` carries the write-data word held at issue. Only its low (count mod 4)+1 bytes are kept, and the rest are zero. On `dn_done` the state returns to IDLE without any valid clear.
- R6: For a read command, `dn_done` in XFER moves the state to HOLD (code 6). `dn_rdata` is captured with the bytes above (count mod 4)+1 forced to zero, and it is readable at offset 0x14.
- R7: In HOLD, a valid-clear write with bit 0 set returns the state to IDLE. The captured read data keeps its value.
- R8: A valid-clear write has no effect in any state other than HOLD. In HOLD, a valid-clear write with bit 0 clear also has no effect.
- R9: A command write while the state is not IDLE is ignored, and the outputs keep the earlier command. Status bit 0 becomes set and stays set until reset.
- R10: The status word is laid out as: state code in bits [3:1], error flag in bit 0, all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| dn_req | output | 1 | Request to the downstream engine |
| dn_cls | output | 2 | Command class |
| dn_wr | output | 1 | Write flag |
| dn_tid | output | 4 | Target ID |
| dn_cnt | output | 8 | Byte count minus one |
| dn_addr | output | 16 | Register address |
| dn_wdata | output | 32 | Lane-masked write data |
| dn_ack | input | 1 | Downstream engine accepts the request |
| dn_done | input | 1 | Downstream engine completes the transfer |
| dn_rdata | input | 32 | Read data returned with `dn_done` |

## Verification
The bench goes after the following corner cases:
- **Command in a busy state.** It issues a command while a transfer is in progress. A design that accepted it would overwrite the outgoing address, and one that forgot the error would show a clean status.
- **Useless valid-clears.** It writes valid-clear in IDLE, and writes a zero valid-clear in HOLD. A loose decode would then drop a held read or corrupt the state code.
- **Every byte count.** Random transfers cover all byte counts mod 4 with random acknowledge and completion delays. Wrong lane masks would leak upper bytes, and an early request drop would lose the handshake.
- **Neighbouring channel window.** It accesses the window of the next channel. A decoder that ignores the upper address bits would act on those accesses.

// File: rtl/cmd_chan_pkg.sv
package cmd_chan_pkg;

    localparam int WORD_W      = 32;
    localparam int CHAN_STRIDE = 64;
    localparam int OFF_W       = $clog2(CHAN_STRIDE);

    localparam logic [OFF_W-1:0] OFS_CMD  = OFF_W'(8'h00);
    localparam logic [OFF_W-1:0] OFS_WDAT = OFF_W'(8'h04);
    localparam logic [OFF_W-1:0] OFS_RDAT = OFF_W'(8'h14);
    localparam logic [OFF_W-1:0] OFS_VCLR = OFF_W'(8'h24);
    localparam logic [OFF_W-1:0] OFS_STAT = OFF_W'(8'h28);

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_ACK = 3'd1,
        ST_XFER     = 3'd2,
        ST_HOLD     = 3'd6
    } chan_state_e;

    typedef struct packed {
        logic [1:0]  cls;
        logic        wr;
        logic        rsvd;
        logic [3:0]  tid;
        logic [7:0]  cnt;
        logic [15:0] addr;
    } cmd_word_t;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] bc);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W / 8; i++) begin
            m[i*8 +: 8] = (i <= int'(bc)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/cmd_chan_decode.sv
module cmd_chan_decode
    import cmd_chan_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CHAN_SEL = 2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wbit0,
    output logic              hit_cmd,
    output logic              hit_wdat,
    output logic              hit_clr,
    output logic [3:0]        rsel
);
    localparam int CSEL_W = ADDR_W - OFF_W;
    localparam logic [CSEL_W-1:0] CSEL = CSEL_W'(CHAN_SEL);
    localparam int NREG = 4;
    localparam logic [OFF_W-1:0] RD_OFS [NREG] = '{OFS_CMD, OFS_WDAT, OFS_RDAT, OFS_STAT};

    logic               in_win;
    logic [OFF_W-1:0]   ofs;

    assign in_win = (bus_addr[ADDR_W-1:OFF_W] == CSEL);
    assign ofs    = bus_addr[OFF_W-1:0];

    for (genvar g = 0; g < NREG; g++) begin : g_rsel
        assign rsel[g] = in_win && (ofs == RD_OFS[g]);
    end

    always_comb begin
        hit_cmd  = bus_wr && in_win && (ofs == OFS_CMD);
        hit_wdat = bus_wr && in_win && (ofs == OFS_WDAT);
        hit_clr  = bus_wr && in_win && (ofs == OFS_VCLR) && wbit0;
    end

endmodule

// File: rtl/cmd_chan_fsm.sv
module cmd_chan_fsm
    import cmd_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_cmd,
    input  logic        hit_clr,
    input  logic        is_wr,
    input  logic        dn_ack,
    input  logic        dn_done,
    output chan_state_e st,
    output logic        accept,
    output logic        capture,
    output logic        req,
    output logic        err
);
    chan_state_e st_q, st_d;
    logic        err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            if (hit_cmd && st_q != ST_IDLE) err_q <= 1'b1;
        end
    end

    // transitions: issue, accept, finish_wr, finish_rd, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (hit_cmd) st_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (dn_ack)  st_d = ST_XFER;
            ST_XFER:     if (dn_done) st_d = is_wr ? ST_IDLE : ST_HOLD;
            ST_HOLD:     if (hit_clr) st_d = ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        req     = 1'b0;
        unique case (st_q)
            ST_IDLE:     accept  = hit_cmd;
            ST_WAIT_ACK: req     = 1'b1;
            ST_XFER:     capture = dn_done && !is_wr;
            ST_HOLD:     ;
            default:     ;
        endcase
    end

    assign st  = st_q;
    assign err = err_q;

endmodule

// File: rtl/cmd_chan_data.sv
module cmd_chan_data
    import cmd_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_wdat,
    input  logic              accept,
    input  logic              capture,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] dn_rdata,
    input  logic [3:0]        rsel,
    input  chan_state_e       st,
    input  logic              err,
    output cmd_word_t         cmd_q,
    output logic [WORD_W-1:0] dn_wdata,
    output logic [WORD_W-1:0] rd_q,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [WORD_W-1:0] wd_reg, wd_q, stat_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_reg <= '0;
            wd_q   <= '0;
            cmd_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (hit_wdat) wd_reg <= bus_wdata;
            if (accept) begin
                cmd_q <= cmd_word_t'(bus_wdata);
                wd_q  <= wd_reg;
            end
            if (capture) rd_q <= dn_rdata & lane_mask(cmd_q.cnt[1:0]);
        end
    end

    assign dn_wdata = wd_q & lane_mask(cmd_q.cnt[1:0]);
    assign stat_w   = {{(WORD_W-4){1'b0}}, st, err};

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            rsel[0]: bus_rdata = cmd_q;
            rsel[1]: bus_rdata = wd_reg;
            rsel[2]: bus_rdata = rd_q;
            rsel[3]: bus_rdata = stat_w;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmd_chan_top.sv
module cmd_chan_top
    import cmd_chan_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CHAN_SEL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dn_req,
    output logic [1:0]        dn_cls,
    output logic              dn_wr,
    output logic [3:0]        dn_tid,
    output logic [7:0]        dn_cnt,
    output logic [15:0]       dn_addr,
    output logic [31:0]       dn_wdata,
    input  logic              dn_ack,
    input  logic              dn_done,
    input  logic [31:0]       dn_rdata
);
    logic        hit_cmd, hit_wdat, hit_clr, accept, capture, err_w;
    logic [3:0]  rsel;
    chan_state_e st_w;
    cmd_word_t   cmd_q;
    logic [31:0] rd_hold;

    cmd_chan_decode #(.ADDR_W(ADDR_W), .CHAN_SEL(CHAN_SEL)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wbit0    (bus_wdata[0]),
        .hit_cmd  (hit_cmd),
        .hit_wdat (hit_wdat),
        .hit_clr  (hit_clr),
        .rsel     (rsel)
    );

    cmd_chan_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_cmd (hit_cmd),
        .hit_clr (hit_clr),
        .is_wr   (cmd_q.wr),
        .dn_ack  (dn_ack),
        .dn_done (dn_done),
        .st      (st_w),
        .accept  (accept),
        .capture (capture),
        .req     (dn_req),
        .err     (err_w)
    );

    cmd_chan_data u_dat (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_wdat  (hit_wdat),
        .accept    (accept),
        .capture   (capture),
        .bus_wdata (bus_wdata),
        .dn_rdata  (dn_rdata),
        .rsel      (rsel),
        .st        (st_w),
        .err       (err_w),
        .cmd_q     (cmd_q),
        .dn_wdata  (dn_wdata),
        .rd_q      (rd_hold),
        .bus_rdata (bus_rdata)
    );

    assign dn_cls  = cmd_q.cls;
    assign dn_wr   = cmd_q.wr;
    assign dn_tid  = cmd_q.tid;
    assign dn_cnt  = cmd_q.cnt;
    assign dn_addr = cmd_q.addr;

endmodule

// File: rtl/cmd_chan_chk.sv
module cmd_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  st,
    input logic        hit_cmd,
    input logic        hit_clr,
    input logic        err,
    input logic        req,
    input logic        ack,
    input logic [31:0] rd_hold
);
    // R3
    issue_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && $past(st) != 3'd1) |-> $past(st) == 3'd0);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    // R7
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6 && !hit_clr) |=> st == 3'd6);

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6) |=> $stable(rd_hold));

    // R9
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cmd && st != 3'd0) |=> err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind cmd_chan_top cmd_chan_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st_w),
    .hit_cmd (hit_cmd),
    .hit_clr (hit_clr),
    .err     (err_w),
    .req     (dn_req),
    .ack     (dn_ack),
    .rd_hold (rd_hold)
);

// File: tb/cmd_chan_top_test.sv
module cmd_chan_top_test;
    localparam int AW = 12;
    localparam logic [AW-1:0] BASE  = 12'h080;
    localparam logic [AW-1:0] A_CMD = BASE + 12'h00;
    localparam logic [AW-1:0] A_WD  = BASE + 12'h04;
    localparam logic [AW-1:0] A_RD  = BASE + 12'h14;
    localparam logic [AW-1:0] A_CLR = BASE + 12'h24;
    localparam logic [AW-1:0] A_ST  = BASE + 12'h28;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, dn_ack = 0, dn_done = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, dn_rdata = '0, bus_rdata, dn_wdata;
    logic dn_req, dn_wr;
    logic [1:0] dn_cls;
    logic [3:0] dn_tid;
    logic [7:0] dn_cnt;
    logic [15:0] dn_addr;

    int total = 0, bad = 0;
    logic exp_err = 0;

    always #4 clk = ~clk;

    cmd_chan_top #(.ADDR_W(AW), .CHAN_SEL(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dn_req(dn_req),
        .dn_cls(dn_cls), .dn_wr(dn_wr), .dn_tid(dn_tid), .dn_cnt(dn_cnt),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
        .dn_done(dn_done), .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] mask_of(input logic [7:0] cnt);
        case (cnt[1:0])
            2'd0: return 32'h0000_00FF;
            2'd1: return 32'h0000_FFFF;
            2'd2: return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] stat_of(input logic [2:0] code, input logic e);
        return {28'd0, code, e};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // full transaction; bursts a busy command into XFER when poke set
    task automatic txn(input logic [31:0] w, input logic [31:0] d, input int adly,
                       input int ddly, input logic [31:0] r, input bit poke);
        logic [31:0] v;
        logic [7:0] cnt;
        cnt = w[23:16];
        if (w[29]) wr(A_WD, d);
        wr(A_CMD, w);
        rd(A_ST, v);
        chk(v == stat_of(3'd1, exp_err), "R3 status wait-ack", v, stat_of(3'd1, exp_err));
        chk({dn_cls, dn_wr, 1'b0, dn_tid, dn_cnt, dn_addr} == w, "R3 unpacked fields",
            {dn_cls, dn_wr, 1'b0, dn_tid, dn_cnt, dn_addr}, w);
        idle_cycles(adly);
        chk(dn_req == 1'b1, "R4 req held", {31'd0, dn_req}, 32'd1);
        dn_ack = 1;
        @(negedge clk);
        dn_ack = 0;
        rd(A_ST, v);
        chk(v == stat_of(3'd2, exp_err) && !dn_req, "R4 xfer after ack", v, stat_of(3'd2, exp_err));
        if (w[29]) chk(dn_wdata == (d & mask_of(cnt)), "R5 write lanes", dn_wdata, d & mask_of(cnt));
        if (poke) begin
            wr(A_CMD, ~w & 32'hEFFF_FFFF);
            exp_err = 1;
            rd(A_ST, v);
            chk(v == stat_of(3'd2, 1'b1), "R9 busy command ignored, err set", v, stat_of(3'd2, 1'b1));
            chk(dn_addr == w[15:0], "R9 fields kept", {16'd0, dn_addr}, {16'd0, w[15:0]});
        end
        idle_cycles(ddly);
        dn_done = 1; dn_rdata = r;
        @(negedge clk);
        dn_done = 0;
        rd(A_ST, v);
        if (w[29]) begin
            chk(v == stat_of(3'd0, exp_err), "R5 write back to idle", v, stat_of(3'd0, exp_err));
        end else begin
            chk(v == stat_of(3'd6, exp_err), "R6 hold state", v, stat_of(3'd6, exp_err));
            rd(A_RD, v);
            chk(v == (r & mask_of(cnt)), "R6 read lanes", v, r & mask_of(cnt));
            wr(A_CLR, 32'd1);
            rd(A_ST, v);
            chk(v == stat_of(3'd0, exp_err), "R7 release to idle", v, stat_of(3'd0, exp_err));
            rd(A_RD, v);
            chk(v == (r & mask_of(cnt)), "R7 data kept", v, r & mask_of(cnt));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd2024));
        idle_cycles(3);
        rst_n = 1;
        @(negedge clk);
        rd(A_ST, v);
        chk(v == 32'd0 && !dn_req, "R1 reset state", v, 32'd0);

        // R2: neighbour window ignored
        wr(BASE + 12'h40, 32'h4123_0055);
        rd(A_ST, v);
        chk(v == 32'd0 && !dn_req, "R2 neighbour cmd ignored", v, 32'd0);
        rd(BASE + 12'h68, v);
        chk(v == 32'd0, "R2 neighbour read zero", v, 32'd0);
        wr(A_WD, 32'hCAFE_F00D);
        rd(A_WD, v);
        chk(v == 32'hCAFE_F00D, "R2 write-data register", v, 32'hCAFE_F00D);

        // R8: clear in idle does nothing
        wr(A_CLR, 32'd1);
        rd(A_ST, v);
        chk(v == 32'd0, "R8 clear in idle", v, 32'd0);

        // directed read with zero clear in hold
        wr(A_CMD, 32'h4203_1234);
        dn_ack = 1; @(negedge clk); dn_ack = 0;
        dn_done = 1; dn_rdata = 32'hA1B2_C3D4; @(negedge clk); dn_done = 0;
        wr(A_CLR, 32'd0);
        rd(A_ST, v);
        chk(v == stat_of(3'd6, 1'b0), "R8 zero clear in hold", v, stat_of(3'd6, 1'b0));
        rd(A_RD, v);
        chk(v == 32'hA1B2_C3D4, "R6 full word read", v, 32'hA1B2_C3D4);
        wr(A_CLR, 32'd1);
        rd(A_ST, v);
        chk(v == 32'd0, "R10 status idle clean", v, 32'd0);

        // R9 directed: busy command during a write
        txn(32'h6500_0042, 32'h1122_3344, 1, 1, 32'd0, 1'b1);
        rd(A_ST, v);
        chk(v == 32'd1, "R10 err only in bit0", v, 32'd1);

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [31:0] w;
            w = $urandom & 32'hEFFF_FFFF;
            txn(w, $urandom, $urandom_range(0, 3), $urandom_range(0, 4), $urandom, 1'b0);
        end

        rd(A_ST, v);
        chk(v == 32'd1, "R9 err sticky", v, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule